// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This block owns the program counter of a five-stage scalar pipeline and settles every control-flow change while the instruction sits in decode. Each cycle it presents the current PC to an instruction memory that answers one cycle later, and by default it advances the PC by one 4-byte word. The instruction that comes back is shown to the decode stage together with its own PC.

In decode, a dedicated adder forms the branch target while the register file is being read. Once the two source operands arrive, a full-width equality comparator decides whether a conditional branch is taken. Jumps always redirect, and a register-indirect jump takes its target from the first operand. Fetch assumes branches are not taken. When a redirect happens, the single instruction already fetched behind the branch is replaced by a NOP, so a taken branch costs one cycle.

A stall input freezes fetch and decode. A redirect from the writeback stage, such as an exception handler address, overrides everything else.

Top module: `decode_redirect_unit`

## Requirements
- R1: With no stall, no redirect and no exception, the PC on `imem_addr_o` grows by 4 on every clock.
- R2: An instruction whose address was on `imem_addr_o` before a clock edge appears on `dec_instr_o` after that edge, and `dec_pc_o` then shows that address.
- R3: A conditional branch has opcode bits [31:26] equal to 0x10 (branch-if-equal) or 0x11 (branch-if-not-equal) and a signed word offset in bits [15:0]. Its target is `dec_pc_o` + 4 + (sign-extended offset × 4), shown on `br_tgt_o`.
- R4: The branch condition compares all 32 bits of `rs_val_i` and `rt_val_i`, so operands that differ only in bit 31 count as unequal.
- R5: Opcode 0x12 jumps to {upper 4 bits of (`dec_pc_o`+4), bits [25:0], 2'b00}. Opcode 0x13 jumps to `rs_val_i`. Both always raise `br_taken_o`.
- R6: On the clock edge that applies a redirect, the PC loads the target. During the following cycle `dec_instr_o` is the NOP word 0x00000000 and `br_taken_o` is low. One cycle later, decode shows the instruction at the target.
- R7: While `stall_i` is high, `imem_req_o` is low, `br_taken_o` is low, and the PC, `dec_pc_o` and `dec_instr_o` hold their values.
- R8: When `xcpt_i` is high, the PC loads `xcpt_tgt_i` at the next edge even if a branch is taken or `stall_i` is high, and `br_taken_o` stays low. The decode slot then shows the NOP word.
- R9: After reset, `imem_addr_o` equals `RESET_VEC`, `dec_instr_o` is the NOP word and `br_taken_o` is low.
- R10: Any other opcode never raises `br_taken_o`, even when the operands are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freeze fetch and decode |
| xcpt_i | input | 1 | Redirect from writeback |
| xcpt_tgt_i | input | 32 | Address for the writeback redirect |
| imem_addr_o | output | 32 | Current PC sent to instruction memory |
| imem_req_o | output | 1 | Read enable; instruction memory holds its output when low |
| imem_rdata_i | input | 32 | Instruction returned one cycle after the address |
| rs_val_i | input | 32 | First source operand read in decode |
| rt_val_i | input | 32 | Second source operand read in decode |
| dec_instr_o | output | 32 | Instruction in decode, NOP when squashed |
| dec_pc_o | output | 32 | PC of the instruction in decode |
| br_taken_o | output | 1 | Decode redirect taken this cycle |
| br_tgt_o | output | 32 | Target of the decode redirect |

## Verification
The redirect outputs `br_taken_o` and `br_tgt_o` are combinational from the decode slot and the operands, so they are checked in the same cycle an input changes. A new PC on `imem_addr_o` is due one edge after the redirect is accepted. The squashed NOP is due in decode during that same cycle, and the target instruction and its PC arrive one edge after that. The bench drives its inputs on the falling edge and samples on the next falling edge, advancing exactly one rising edge between samples. In this way each expected value is compared in the cycle where the register count places it.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned OP_W  = 6;
  localparam int unsigned IMM_W = 16;
  localparam int unsigned IDX_W = 26;
  localparam int unsigned OP_LO = XLEN - OP_W;

  localparam logic [OP_W-1:0] OPC_BEQ  = 6'h10;
  localparam logic [OP_W-1:0] OPC_BNE  = 6'h11;
  localparam logic [OP_W-1:0] OPC_JMP  = 6'h12;
  localparam logic [OP_W-1:0] OPC_JREG = 6'h13;

  localparam logic [XLEN-1:0] NOP_WORD   = '0;
  localparam logic [XLEN-1:0] INSN_BYTES = 4;

  typedef struct packed {
    logic            take;
    logic [XLEN-1:0] tgt;
  } redir_t;
endpackage

// File: rtl/bru_pc_gen.sv
module bru_pc_gen
  import bru_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0040
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            xcpt_i,
  input  logic [XLEN-1:0] xcpt_tgt_i,
  input  redir_t          br_i,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] pc_q, pc_d;

  // priority: writeback redirect > stall hold > decode redirect > sequential
  always_comb begin
    if (xcpt_i)         pc_d = xcpt_tgt_i;
    else if (stall_i)   pc_d = pc_q;
    else if (br_i.take) pc_d = br_i.tgt;
    else                pc_d = pc_q + INSN_BYTES;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_VEC;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  assert_seq_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !xcpt_i && !br_i.take) |=> (pc_q == $past(pc_q) + INSN_BYTES));

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !xcpt_i) |=> $stable(pc_q));

  assert_xcpt_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xcpt_i |=> (pc_q == $past(xcpt_tgt_i)));

  assert_redir_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_i.take && !stall_i && !xcpt_i) |=> (pc_q == $past(br_i.tgt)));
endmodule

// File: rtl/bru_dec_reg.sv
module bru_dec_reg
  import bru_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            kill_i,
  input  logic            xcpt_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] dec_pc_o,
  output logic            dec_vld_o
);
  logic [XLEN-1:0] dpc_q;
  logic            vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dpc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (adv_i) dpc_q <= pc_i;
      // incoming word is the wrong-path fetch after any redirect
      if (xcpt_i)     vld_q <= 1'b0;
      else if (adv_i) vld_q <= !kill_i;
    end
  end

  assign dec_pc_o  = dpc_q;
  assign dec_vld_o = vld_q;

  assert_squash_after_redir_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && kill_i) |=> !vld_q);

  assert_xcpt_squash_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xcpt_i |=> !vld_q);

  assert_dec_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !xcpt_i) |=> ($stable(dpc_q) && $stable(vld_q)));
endmodule

// File: rtl/bru_branch_eval.sv
module bru_branch_eval
  import bru_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            vld_i,
  input  logic            stall_i,
  input  logic            xcpt_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output redir_t          br_o
);
  localparam int unsigned SEXT_W = XLEN - IMM_W - 2;
  localparam int unsigned HI_W   = XLEN - IDX_W - 2;

  logic [OP_W-1:0]  opc;
  logic [IMM_W-1:0] off;
  logic [XLEN-1:0]  pc4, br_tgt, jmp_tgt;
  logic             ops_eq, en;

  assign opc = instr_i[XLEN-1:OP_LO];
  assign off = instr_i[IMM_W-1:0];
  assign pc4 = pc_i + INSN_BYTES;

  // dedicated target adder, runs alongside the operand read
  assign br_tgt  = pc4 + {{SEXT_W{off[IMM_W-1]}}, off, 2'b00};
  assign jmp_tgt = {pc4[XLEN-1:XLEN-HI_W], instr_i[IDX_W-1:0], 2'b00};
  assign ops_eq  = (rs_i == rt_i);
  assign en      = vld_i && !stall_i && !xcpt_i;

  always_comb begin
    br_o = '0;
    if (en) begin
      unique case (opc)
        OPC_BEQ:  br_o = '{take: ops_eq,  tgt: br_tgt};
        OPC_BNE:  br_o = '{take: !ops_eq, tgt: br_tgt};
        OPC_JMP:  br_o = '{take: 1'b1,    tgt: jmp_tgt};
        OPC_JREG: br_o = '{take: 1'b1,    tgt: rs_i};
        default:  br_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/decode_redirect_unit.sv
module decode_redirect_unit
  import bru_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0000_0040
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stall_i,
  input  logic        xcpt_i,
  input  logic [31:0] xcpt_tgt_i,
  output logic [31:0] imem_addr_o,
  output logic        imem_req_o,
  input  logic [31:0] imem_rdata_i,
  input  logic [31:0] rs_val_i,
  input  logic [31:0] rt_val_i,
  output logic [31:0] dec_instr_o,
  output logic [31:0] dec_pc_o,
  output logic        br_taken_o,
  output logic [31:0] br_tgt_o
);
  logic [XLEN-1:0] pc, dpc;
  logic            dvld;
  redir_t          br;

  bru_pc_gen #(.RESET_VEC(RESET_VEC)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stall_i    (stall_i),
    .xcpt_i     (xcpt_i),
    .xcpt_tgt_i (xcpt_tgt_i),
    .br_i       (br),
    .pc_o       (pc)
  );

  bru_dec_reg u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (!stall_i),
    .kill_i    (br.take),
    .xcpt_i    (xcpt_i),
    .pc_i      (pc),
    .dec_pc_o  (dpc),
    .dec_vld_o (dvld)
  );

  bru_branch_eval u_eval (
    .instr_i (imem_rdata_i),
    .pc_i    (dpc),
    .vld_i   (dvld),
    .stall_i (stall_i),
    .xcpt_i  (xcpt_i),
    .rs_i    (rs_val_i),
    .rt_i    (rt_val_i),
    .br_o    (br)
  );

  assign imem_addr_o = pc;
  assign imem_req_o  = !stall_i;
  assign dec_instr_o = dvld ? imem_rdata_i : NOP_WORD;
  assign dec_pc_o    = dpc;
  assign br_taken_o  = br.take;
  assign br_tgt_o    = br.tgt;

  assert_no_redir_in_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !br_taken_o);

  assert_xcpt_masks_branch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xcpt_i |-> !br_taken_o);

  assert_no_double_redir_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_taken_o && !xcpt_i) |=> !br_taken_o);
endmodule

// File: tb/sim_decode_redirect_unit.sv
`timescale 1ns/1ps
module sim_decode_redirect_unit;
  localparam logic [31:0] RV = 32'h0000_0040;

  logic        clk = 1'b0;
  logic        rst_n, stall, xcpt;
  logic [31:0] xtgt, addr, rdata, rs, rt, dinstr, dpc, tgt;
  logic        req, taken;
  logic [31:0] mem [64];
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (req) rdata <= mem[addr[7:2]];

  decode_redirect_unit #(.RESET_VEC(RV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .xcpt_i(xcpt), .xcpt_tgt_i(xtgt),
    .imem_addr_o(addr), .imem_req_o(req), .imem_rdata_i(rdata),
    .rs_val_i(rs), .rt_val_i(rt), .dec_instr_o(dinstr), .dec_pc_o(dpc),
    .br_taken_o(taken), .br_tgt_o(tgt)
  );

  function automatic logic [31:0] filler(int i);
    return 32'h0400_0000 | 32'(i);
  endfunction
  function automatic logic [31:0] cbr(logic [5:0] op, logic [15:0] off);
    return {op, 10'h0, off};
  endfunction

  task automatic chk(string req_s, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req_s, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; stall = 1'b0; xcpt = 1'b0; xtgt = '0; rs = '0; rt = '0; rdata = '0;
    for (int i = 0; i < 64; i++) mem[i] = filler(i);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_sequential();
    do_reset();
    chk("R9 addr", addr, RV);
    chk("R9 nop", dinstr, 32'h0);
    chk("R9 taken", {31'h0, taken}, 32'h0);
    step();
    chk("R1 addr", addr, RV + 4);
    chk("R2 dec_pc", dpc, RV);
    chk("R2 instr", dinstr, mem[16]);
    step();
    chk("R1 addr2", addr, RV + 8);
    chk("R2 instr2", dinstr, mem[17]);
  endtask

  task automatic t_beq_taken();
    do_reset();
    mem[16] = cbr(6'h10, 16'd5); rs = 32'h1234; rt = 32'h1234;
    step();
    chk("R3 taken", {31'h0, taken}, 32'h1);
    chk("R3 tgt", tgt, 32'h58);
    step();
    chk("R6 nop", dinstr, 32'h0);
    chk("R6 no_redir", {31'h0, taken}, 32'h0);
    chk("R6 addr", addr, 32'h58);
    step();
    chk("R6 dec_pc", dpc, 32'h58);
    chk("R6 instr", dinstr, mem[22]);
  endtask

  task automatic t_beq_not_taken();
    do_reset();
    mem[16] = cbr(6'h10, 16'd5); rs = 32'h8000_0000; rt = 32'h0;
    step();
    chk("R4 msb_diff", {31'h0, taken}, 32'h0);
    step();
    chk("R4 seq_pc", dpc, RV + 4);
    chk("R4 seq_instr", dinstr, mem[17]);
  endtask

  task automatic t_bne_back();
    do_reset();
    mem[16] = cbr(6'h11, 16'hFFFD); rs = 32'h1; rt = 32'h2;
    step();
    chk("R4 bne_taken", {31'h0, taken}, 32'h1);
    chk("R3 neg_tgt", tgt, 32'h38);
    step(); step();
    chk("R3 neg_land", dinstr, mem[14]);
  endtask

  task automatic t_jumps();
    do_reset();
    mem[16] = {6'h12, 26'h20};
    step();
    chk("R5 jmp_taken", {31'h0, taken}, 32'h1);
    chk("R5 jmp_tgt", tgt, 32'h80);
    step(); step();
    chk("R5 jmp_land", dinstr, mem[32]);
    do_reset();
    mem[16] = {6'h13, 26'h0}; rs = 32'h64; rt = 32'h7;
    step();
    chk("R5 jreg_taken", {31'h0, taken}, 32'h1);
    chk("R5 jreg_tgt", tgt, 32'h64);
    step(); step();
    chk("R5 jreg_land", dinstr, mem[25]);
  endtask

  task automatic t_other_op();
    do_reset();
    mem[16] = 32'h5000_0003; rs = 32'h9; rt = 32'h9;
    step();
    chk("R10 no_taken", {31'h0, taken}, 32'h0);
    step();
    chk("R10 seq", dpc, RV + 4);
  endtask

  task automatic t_stall();
    do_reset();
    mem[16] = cbr(6'h10, 16'd5); rs = 32'h5; rt = 32'h5;
    step();
    stall = 1'b1;
    #0.1;
    chk("R7 taken_low", {31'h0, taken}, 32'h0);
    chk("R7 req_low", {31'h0, req}, 32'h0);
    step();
    chk("R7 addr_hold", addr, RV + 4);
    chk("R7 pc_hold", dpc, RV);
    chk("R7 instr_hold", dinstr, mem[16]);
    stall = 1'b0;
    #0.1;
    chk("R7 resume_taken", {31'h0, taken}, 32'h1);
    step();
    chk("R7 resume_addr", addr, 32'h58);
  endtask

  task automatic t_xcpt();
    do_reset();
    mem[16] = cbr(6'h10, 16'd5); rs = 32'h5; rt = 32'h5;
    step();
    xcpt = 1'b1; xtgt = 32'h20; stall = 1'b1;
    #0.1;
    chk("R8 masks_branch", {31'h0, taken}, 32'h0);
    step();
    xcpt = 1'b0; stall = 1'b0;
    chk("R8 addr", addr, 32'h20);
    chk("R8 nop", dinstr, 32'h0);
    step();
    chk("R8 land_pc", dpc, 32'h20);
    chk("R8 land", dinstr, mem[8]);
  endtask

  initial begin
    t_sequential();
    t_beq_taken();
    t_beq_not_taken();
    t_bne_back();
    t_jumps();
    t_other_op();
    t_stall();
    t_xcpt();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule